// File: doc/BRIEF.md
# Store Buffer with Two-Stage Load Forwarding

The block holds committed stores between the store execution path and the first-level data cache. A store is written into an eight-entry FIFO and completes in the cycle it is presented. The FIFO writes its oldest entry to the cache whenever the cache write port is ready. The producer sees a stall only when all eight entries are occupied.

Every load is compared with the buffered stores. The first comparison is fast and looks only at a twelve-bit slice of the word address (address bits 13..2). If no entry matches, the load goes to the cache in the same cycle. If any entry matches, the load moves into a verify stage for one cycle. There the full word address is compared, and the youngest fully matching store supplies the data when the address, size and alignment allow it. A match on the slice alone is a false positive: the load is sent to the cache one cycle late. A true match that cannot be forwarded holds the load until every matching store has drained, and the load is then sent to the cache.

Sizes are encoded 0 = byte, 1 = halfword, 2 = word; 3 is reserved and never forwarded. Forwarded data is the store's data masked to the low 8, 16 or 32 bits for sizes 0, 1 and 2.

Top module: `store_fwd_queue`

## Requirements
- R1: When fewer than 8 stores are held, `stReady` is 1 and a store presented with `stValid` is taken at that clock edge. It appears on the cache write port in the next cycle if the buffer was empty.
- R2: With 8 stores held, `stReady` is 0, and a store presented then is not taken. `stReady` returns to 1 after an entry drains.
- R3: `cacheWrValid` is 1 whenever the buffer holds a store. `cacheWrAddr`, `cacheWrSize` and `cacheWrData` show the oldest entry, and the next entry in store order follows each cycle in which `cacheWrReady` is 1.
- R4: A load is accepted when `ldValid` is 1 and `ldBusy` is 0. If address bits 13..2 of an accepted load match no held store, `cacheRdValid` is 1 in that same cycle, with `cacheRdAddr` and `cacheRdSize` equal to the load's address and size.
- R5: If a held store has the same full address and size as the load, and the address is aligned to the size (halfword: bit 0 is 0; word: bits 1..0 are 0), then `ldFwdValid` is 1 in the cycle after acceptance. `ldFwdData` carries the masked store data, and no cache read is issued for that load.
- R6: When several held stores match a load, the data comes from the one accepted most recently.
- R7: If bits 13..2 match but no held store has the same word address (bits 31..2), `cacheRdValid` is 1 in the cycle after acceptance with the load's address. Nothing is forwarded.
- R8: If the youngest store with the same word address differs from the load in byte offset or size, or the access is misaligned, the load is not forwarded. `ldBusy` stays 1 while such a store is held. `cacheRdValid` is raised with the load's address in the cycle after the last such store has drained.
- R9: A load does not see a store presented in the same cycle.
- R10: After reset the buffer is empty: `stReady` is 1, and `cacheWrValid`, `ldBusy`, `ldFwdValid` and `cacheRdValid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stValid | input | 1 | Store presented |
| stReady | output | 1 | Buffer has a free entry |
| stAddr | input | 32 | Store byte address |
| stSize | input | 2 | Store size (0 byte, 1 half, 2 word) |
| stData | input | 32 | Store data, right-aligned |
| ldValid | input | 1 | Load presented |
| ldBusy | output | 1 | Verify stage occupied; loads not accepted |
| ldAddr | input | 32 | Load byte address |
| ldSize | input | 2 | Load size |
| ldFwdValid | output | 1 | Forwarded data valid |
| ldFwdData | output | 32 | Forwarded data, masked to the load size |
| cacheRdValid | output | 1 | Load request to the cache |
| cacheRdAddr | output | 32 | Load request address |
| cacheRdSize | output | 2 | Load request size |
| cacheWrValid | output | 1 | Oldest store offered to the cache |
| cacheWrReady | input | 1 | Cache write port takes the offered store |
| cacheWrAddr | output | 32 | Oldest store address |
| cacheWrSize | output | 2 | Oldest store size |
| cacheWrData | output | 32 | Oldest store data |

## Verification
Assertions check several properties on every cycle. The occupancy count always equals the number of valid entries, and the oldest entry is valid whenever the count is nonzero. No store is written into a full buffer and nothing drains from an empty one. A forward only ever occurs the cycle after a load is accepted. A late cache request only ever follows an accepted or waiting load. Other behaviours can only be shown by the bench's scenarios, since they depend on specific address patterns: the choice of the youngest among duplicate stores, the one-cycle penalty of a false slice match, the wait on size, offset or alignment conflicts, and the blindness to a store presented in the same cycle.

// File: rtl/sfq_pkg.sv
package sfq_pkg;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  // Byte-offset bits below the word address
  localparam int OFS_W = 2;

  // Strobes from control to the entry storage
  typedef struct packed {
    logic enq;
    logic deq;
    logic capture;
  } sfqStrobe_t;

  function automatic logic isAligned(input logic [1:0] ofs, input logic [1:0] sz);
    case (sz)
      SZ_BYTE: isAligned = 1'b1;
      SZ_HALF: isAligned = ~ofs[0];
      SZ_WORD: isAligned = (ofs == 2'b00);
      default: isAligned = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/sfq_entries.sv
module sfq_entries
  import sfq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int PART_W = 12,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  sfqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [1:0]        stSize,
  input  logic [DATA_W-1:0] stData,
  input  logic [ADDR_W-1:0] probeAddr,
  input  logic [ADDR_W-1:0] checkAddr,
  input  logic [PTR_W-1:0]  selIdx,
  output logic [DEPTH-1:0]  entValid,
  output logic [DEPTH-1:0]  partHit,
  output logic [DEPTH-1:0]  fullHit,
  output logic [PTR_W-1:0]  headIdx,
  output logic [PTR_W-1:0]  tailIdx,
  output logic [CNT_W-1:0]  count,
  output logic [ADDR_W-1:0] headAddr,
  output logic [1:0]        headSize,
  output logic [DATA_W-1:0] headData,
  output logic [ADDR_W-1:0] selAddr,
  output logic [1:0]        selSize,
  output logic [DATA_W-1:0] selData
);

  localparam int PART_HI = OFS_W + PART_W - 1;

  logic [ADDR_W-1:0] addrMem [DEPTH];
  logic [1:0]        sizeMem [DEPTH];
  logic [DATA_W-1:0] dataMem [DEPTH];
  logic [DEPTH-1:0]  validMem;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    nextPtr = (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // Pointers, occupancy and valid flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headIdx  <= '0;
      tailIdx  <= '0;
      count    <= '0;
      validMem <= '0;
    end else begin
      if (strobe.enq) tailIdx <= nextPtr(tailIdx);
      if (strobe.deq) headIdx <= nextPtr(headIdx);
      case ({strobe.enq, strobe.deq})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (strobe.deq) validMem[headIdx] <= 1'b0;
      if (strobe.enq) validMem[tailIdx] <= 1'b1;
    end
  end

  // Entry payload, written at the tail
  always_ff @(posedge clk) begin
    if (strobe.enq) begin
      addrMem[tailIdx] <= stAddr;
      sizeMem[tailIdx] <= stSize;
      dataMem[tailIdx] <= stData;
    end
  end

  // Per-entry comparators: narrow slice for the probe, full word address for the check
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign partHit[g] = validMem[g] &&
                        (addrMem[g][PART_HI:OFS_W] == probeAddr[PART_HI:OFS_W]);
    assign fullHit[g] = validMem[g] &&
                        (addrMem[g][ADDR_W-1:OFS_W] == checkAddr[ADDR_W-1:OFS_W]);
  end

  assign entValid = validMem;
  assign headAddr = addrMem[headIdx];
  assign headSize = sizeMem[headIdx];
  assign headData = dataMem[headIdx];
  assign selAddr  = addrMem[selIdx];
  assign selSize  = sizeMem[selIdx];
  assign selData  = dataMem[selIdx];

  // R2
  enq_room_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.enq |-> (count < CNT_W'(DEPTH)));

  // R3
  deq_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.deq |-> (count != '0));

  // R3
  occupancy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(validMem) == int'(count));

  // R3
  head_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (count != '0) |-> validMem[headIdx]);

endmodule

// File: rtl/sfq_ctrl.sv
module sfq_ctrl
  import sfq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stValid,
  input  logic              ldValid,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [1:0]        ldSize,
  input  logic              cacheWrReady,
  input  logic [CNT_W-1:0]  count,
  input  logic [DEPTH-1:0]  entValid,
  input  logic [DEPTH-1:0]  partHit,
  input  logic [DEPTH-1:0]  fullHit,
  input  logic [PTR_W-1:0]  headIdx,
  input  logic [PTR_W-1:0]  tailIdx,
  input  logic [ADDR_W-1:0] selAddr,
  input  logic [1:0]        selSize,
  input  logic [DATA_W-1:0] selData,
  output sfqStrobe_t        strobe,
  output logic [PTR_W-1:0]  selIdx,
  output logic [ADDR_W-1:0] checkAddr,
  output logic              stReady,
  output logic              ldBusy,
  output logic              ldFwdValid,
  output logic [DATA_W-1:0] ldFwdData,
  output logic              cacheRdValid,
  output logic [ADDR_W-1:0] cacheRdAddr,
  output logic [1:0]        cacheRdSize,
  output logic              cacheWrValid
);

  logic              s2Valid;
  logic [ADDR_W-1:0] s2Addr;
  logic [1:0]        s2Size;
  logic [DEPTH-1:0]  s2Mask;

  logic [DEPTH-1:0]  drainMask;
  logic [DEPTH-1:0]  livePart;
  logic [DEPTH-1:0]  liveFull;
  logic              ldAccept;
  logic              anyPart;
  logic              selFound;
  logic              fwdOk;
  logic              waitHit;
  logic [DATA_W-1:0] fwdMask;

  assign stReady      = (count < CNT_W'(DEPTH));
  assign cacheWrValid = (count != '0);
  assign ldBusy       = s2Valid;
  assign ldAccept     = ldValid && !s2Valid;

  always_comb begin
    drainMask = '0;
    if (strobe.deq) drainMask[headIdx] = 1'b1;
  end

  // An entry leaving this cycle is already in the cache: it does not count as a hit
  assign livePart = partHit & ~drainMask;
  assign anyPart  = |livePart;

  always_comb begin
    strobe.enq     = stValid && stReady;
    strobe.deq     = cacheWrValid && cacheWrReady;
    strobe.capture = ldAccept && anyPart;
  end

  // Verify stage: full compare limited to the entries captured at the probe
  assign checkAddr = s2Addr;
  assign liveFull  = s2Mask & fullHit;

  // Youngest full match: walk backwards from the tail
  always_comb begin
    int pos;
    selFound = 1'b0;
    selIdx   = '0;
    for (int k = 1; k <= DEPTH; k++) begin
      pos = int'(tailIdx) - k;
      if (pos < 0) pos = pos + DEPTH;
      if (!selFound && liveFull[pos]) begin
        selFound = 1'b1;
        selIdx   = PTR_W'(pos);
      end
    end
  end

  assign fwdOk = s2Valid && selFound && (selAddr == s2Addr) && (selSize == s2Size) &&
                 isAligned(s2Addr[1:0], s2Size);
  assign waitHit = s2Valid && selFound && !fwdOk;

  always_comb begin
    case (s2Size)
      SZ_BYTE: fwdMask = DATA_W'(8'hFF);
      SZ_HALF: fwdMask = DATA_W'(16'hFFFF);
      default: fwdMask = '1;
    endcase
  end

  assign ldFwdValid = fwdOk;
  assign ldFwdData  = fwdOk ? (selData & fwdMask) : '0;

  // Direct request on a slice miss, late request from the verify stage otherwise
  assign cacheRdValid = (ldAccept && !anyPart) || (s2Valid && !selFound);
  assign cacheRdAddr  = s2Valid ? s2Addr : ldAddr;
  assign cacheRdSize  = s2Valid ? s2Size : ldSize;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s2Valid <= 1'b0;
      s2Addr  <= '0;
      s2Size  <= '0;
      s2Mask  <= '0;
    end else if (strobe.capture) begin
      s2Valid <= 1'b1;
      s2Addr  <= ldAddr;
      s2Size  <= ldSize;
      s2Mask  <= livePart;
    end else if (s2Valid) begin
      if (!waitHit) s2Valid <= 1'b0;
      s2Mask <= s2Mask & ~drainMask;
    end
  end

  // R5
  fwd_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ldFwdValid |-> $past(ldValid && !ldBusy));

  // R7
  late_req_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cacheRdValid && ldBusy) |-> ($past(ldBusy) || $past(ldValid)));

  // R2
  stall_only_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stReady |-> (&entValid));

endmodule

// File: rtl/store_fwd_queue.sv
module store_fwd_queue
  import sfq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int PART_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stValid,
  output logic              stReady,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [1:0]        stSize,
  input  logic [DATA_W-1:0] stData,
  input  logic              ldValid,
  output logic              ldBusy,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [1:0]        ldSize,
  output logic              ldFwdValid,
  output logic [DATA_W-1:0] ldFwdData,
  output logic              cacheRdValid,
  output logic [ADDR_W-1:0] cacheRdAddr,
  output logic [1:0]        cacheRdSize,
  output logic              cacheWrValid,
  input  logic              cacheWrReady,
  output logic [ADDR_W-1:0] cacheWrAddr,
  output logic [1:0]        cacheWrSize,
  output logic [DATA_W-1:0] cacheWrData
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  sfqStrobe_t        strobe;
  logic [PTR_W-1:0]  selIdx;
  logic [PTR_W-1:0]  headIdx;
  logic [PTR_W-1:0]  tailIdx;
  logic [CNT_W-1:0]  count;
  logic [DEPTH-1:0]  entValid;
  logic [DEPTH-1:0]  partHit;
  logic [DEPTH-1:0]  fullHit;
  logic [ADDR_W-1:0] checkAddr;
  logic [ADDR_W-1:0] selAddr;
  logic [1:0]        selSize;
  logic [DATA_W-1:0] selData;

  sfq_entries #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .PART_W(PART_W)
  ) u_entries (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .stAddr    (stAddr),
    .stSize    (stSize),
    .stData    (stData),
    .probeAddr (ldAddr),
    .checkAddr (checkAddr),
    .selIdx    (selIdx),
    .entValid  (entValid),
    .partHit   (partHit),
    .fullHit   (fullHit),
    .headIdx   (headIdx),
    .tailIdx   (tailIdx),
    .count     (count),
    .headAddr  (cacheWrAddr),
    .headSize  (cacheWrSize),
    .headData  (cacheWrData),
    .selAddr   (selAddr),
    .selSize   (selSize),
    .selData   (selData)
  );

  sfq_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .stValid      (stValid),
    .ldValid      (ldValid),
    .ldAddr       (ldAddr),
    .ldSize       (ldSize),
    .cacheWrReady (cacheWrReady),
    .count        (count),
    .entValid     (entValid),
    .partHit      (partHit),
    .fullHit      (fullHit),
    .headIdx      (headIdx),
    .tailIdx      (tailIdx),
    .selAddr      (selAddr),
    .selSize      (selSize),
    .selData      (selData),
    .strobe       (strobe),
    .selIdx       (selIdx),
    .checkAddr    (checkAddr),
    .stReady      (stReady),
    .ldBusy       (ldBusy),
    .ldFwdValid   (ldFwdValid),
    .ldFwdData    (ldFwdData),
    .cacheRdValid (cacheRdValid),
    .cacheRdAddr  (cacheRdAddr),
    .cacheRdSize  (cacheRdSize),
    .cacheWrValid (cacheWrValid)
  );

endmodule

// File: tb/store_fwd_queue_bench.sv
`timescale 1ns/1ps
module store_fwd_queue_bench;

  localparam logic [1:0] K_NOW  = 2'd0;
  localparam logic [1:0] K_FWD  = 2'd1;
  localparam logic [1:0] K_LATE = 2'd2;

  typedef struct packed {
    logic        isSt;
    logic [31:0] addr;
    logic [1:0]  size;
    logic [31:0] data;
    logic [1:0]  kind;
  } vec_t;

  // Stores fill the buffer (no draining); loads probe it
  localparam vec_t VECS [10] = '{
    '{1'b1, 32'h0000_1000, 2'd2, 32'h1111_1111, K_NOW},
    '{1'b1, 32'h0000_2004, 2'd1, 32'h1234_BEEF, K_NOW},
    '{1'b1, 32'h0000_1000, 2'd2, 32'h2222_2222, K_NOW},
    '{1'b0, 32'h0000_1000, 2'd2, 32'h2222_2222, K_FWD},
    '{1'b0, 32'h0000_3000, 2'd2, 32'h0000_0000, K_NOW},
    '{1'b0, 32'h0001_1000, 2'd2, 32'h0000_0000, K_LATE},
    '{1'b0, 32'h0000_2004, 2'd1, 32'h0000_BEEF, K_FWD},
    '{1'b1, 32'h0000_4003, 2'd0, 32'hFFFF_FFA5, K_NOW},
    '{1'b0, 32'h0000_4003, 2'd0, 32'h0000_00A5, K_FWD},
    '{1'b0, 32'h0000_5008, 2'd2, 32'h0000_0000, K_NOW}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stValid = 1'b0;
  logic        stReady;
  logic [31:0] stAddr = '0;
  logic [1:0]  stSize = '0;
  logic [31:0] stData = '0;
  logic        ldValid = 1'b0;
  logic        ldBusy;
  logic [31:0] ldAddr = '0;
  logic [1:0]  ldSize = '0;
  logic        ldFwdValid;
  logic [31:0] ldFwdData;
  logic        cacheRdValid;
  logic [31:0] cacheRdAddr;
  logic [1:0]  cacheRdSize;
  logic        cacheWrValid;
  logic        cacheWrReady = 1'b0;
  logic [31:0] cacheWrAddr;
  logic [1:0]  cacheWrSize;
  logic [31:0] cacheWrData;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  store_fwd_queue u_store_fwd_queue (
    .clk(clk), .rstN(rstN),
    .stValid(stValid), .stReady(stReady), .stAddr(stAddr), .stSize(stSize), .stData(stData),
    .ldValid(ldValid), .ldBusy(ldBusy), .ldAddr(ldAddr), .ldSize(ldSize),
    .ldFwdValid(ldFwdValid), .ldFwdData(ldFwdData),
    .cacheRdValid(cacheRdValid), .cacheRdAddr(cacheRdAddr), .cacheRdSize(cacheRdSize),
    .cacheWrValid(cacheWrValid), .cacheWrReady(cacheWrReady),
    .cacheWrAddr(cacheWrAddr), .cacheWrSize(cacheWrSize), .cacheWrData(cacheWrData)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<20000 cycles", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic storeOp(input logic [31:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    stValid = 1'b1; stAddr = a; stSize = s; stData = d;
    #0.5;
    chk(stReady == 1'b1, "R1", "stReady with room", 32'(stReady), 32'd1);
    @(negedge clk);
    stValid = 1'b0;
  endtask

  task automatic loadOp(input logic [31:0] a, input logic [1:0] s,
                        output logic now, output logic [31:0] nowAddr,
                        output logic fwd, output logic [31:0] fwdData,
                        output logic late, output logic [31:0] lateAddr);
    @(negedge clk);
    ldValid = 1'b1; ldAddr = a; ldSize = s;
    #0.5;
    now = cacheRdValid; nowAddr = cacheRdAddr;
    @(negedge clk);
    ldValid = 1'b0;
    #0.5;
    fwd = ldFwdValid; fwdData = ldFwdData;
    late = cacheRdValid; lateAddr = cacheRdAddr;
  endtask

  initial begin
    logic now, fwd, late;
    logic [31:0] nowAddr, fwdData, lateAddr;
    bit seen;

    // R10: reset state
    repeat (3) @(posedge clk);
    #0.5;
    chk(stReady == 1'b1, "R10", "stReady in reset", 32'(stReady), 32'd1);
    chk(cacheWrValid == 1'b0, "R10", "cacheWrValid in reset", 32'(cacheWrValid), 32'd0);
    chk(ldBusy == 1'b0 && ldFwdValid == 1'b0 && cacheRdValid == 1'b0, "R10",
        "load outputs in reset", {29'd0, ldBusy, ldFwdValid, cacheRdValid}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    // Vector table, no draining
    foreach (VECS[i]) begin
      if (VECS[i].isSt) begin
        storeOp(VECS[i].addr, VECS[i].size, VECS[i].data);
        if (i == 0) begin
          #0.5;
          chk(cacheWrValid && cacheWrAddr == 32'h0000_1000, "R1", "first store offered",
              cacheWrAddr, 32'h0000_1000);
        end
      end else begin
        loadOp(VECS[i].addr, VECS[i].size, now, nowAddr, fwd, fwdData, late, lateAddr);
        case (VECS[i].kind)
          K_NOW: begin
            chk(now && nowAddr == VECS[i].addr, "R4", "same-cycle cache request",
                nowAddr, VECS[i].addr);
            chk(!fwd && !late, "R4", "no stage-two action", {30'd0, fwd, late}, 32'd0);
          end
          K_FWD: begin
            chk(!now && !late, "R5", "no cache request on forward", {30'd0, now, late}, 32'd0);
            chk(fwd && fwdData == VECS[i].data, "R6", "forwarded youngest data",
                fwdData, VECS[i].data);
          end
          default: begin
            chk(!now && !fwd, "R7", "false slice match not forwarded", {30'd0, now, fwd}, 32'd0);
            chk(late && lateAddr == VECS[i].addr, "R7", "late cache request",
                lateAddr, VECS[i].addr);
          end
        endcase
      end
    end

    // R8: size conflict waits for the matching store to drain; R3 drain order
    @(negedge clk);
    ldValid = 1'b1; ldAddr = 32'h0000_2004; ldSize = 2'd0;
    #0.5;
    chk(cacheRdValid == 1'b0, "R8", "no direct request on slice hit", 32'(cacheRdValid), 32'd0);
    @(negedge clk);
    ldValid = 1'b0; cacheWrReady = 1'b1;
    #0.5;
    chk(ldBusy && !ldFwdValid && !cacheRdValid, "R8", "size conflict held",
        {29'd0, ldBusy, ldFwdValid, cacheRdValid}, 32'd4);
    chk(cacheWrAddr == 32'h0000_1000 && cacheWrData == 32'h1111_1111, "R3", "oldest entry",
        cacheWrData, 32'h1111_1111);
    @(negedge clk);
    #0.5;
    chk(ldBusy && !cacheRdValid, "R8", "still held while store present",
        {30'd0, ldBusy, cacheRdValid}, 32'd2);
    chk(cacheWrAddr == 32'h0000_2004 && cacheWrSize == 2'd1, "R3", "second entry",
        cacheWrAddr, 32'h0000_2004);
    @(negedge clk);
    #0.5;
    chk(cacheRdValid && cacheRdAddr == 32'h0000_2004 && cacheRdSize == 2'd0, "R8",
        "request after drain", cacheRdAddr, 32'h0000_2004);
    chk(cacheWrData == 32'h2222_2222, "R3", "third entry", cacheWrData, 32'h2222_2222);
    @(negedge clk);
    #0.5;
    chk(!ldBusy && cacheWrAddr == 32'h0000_4003, "R3", "fourth entry", cacheWrAddr, 32'h0000_4003);
    @(negedge clk);
    #0.5;
    chk(cacheWrValid == 1'b0, "R3", "buffer empty after drain", 32'(cacheWrValid), 32'd0);
    cacheWrReady = 1'b0;

    // R9: store and load in the same cycle
    @(negedge clk);
    stValid = 1'b1; stAddr = 32'h0000_7000; stSize = 2'd2; stData = 32'hCAFE_F00D;
    ldValid = 1'b1; ldAddr = 32'h0000_7000; ldSize = 2'd2;
    #0.5;
    chk(cacheRdValid && cacheRdAddr == 32'h0000_7000, "R9", "same-cycle store unseen",
        32'(cacheRdValid), 32'd1);
    @(negedge clk);
    stValid = 1'b0; ldValid = 1'b0;
    #0.5;
    chk(!ldFwdValid && !ldBusy, "R9", "no forward of same-cycle store",
        {30'd0, ldFwdValid, ldBusy}, 32'd0);
    loadOp(32'h0000_7000, 2'd2, now, nowAddr, fwd, fwdData, late, lateAddr);
    chk(fwd && !now && fwdData == 32'hCAFE_F00D, "R5", "forward after store settled",
        fwdData, 32'hCAFE_F00D);

    // R8: misaligned same-size access is not forwarded
    storeOp(32'h0000_7001, 2'd1, 32'h0000_5555);
    loadOp(32'h0000_7001, 2'd1, now, nowAddr, fwd, fwdData, late, lateAddr);
    chk(!now && !fwd && !late && ldBusy, "R8", "misaligned held",
        {28'd0, now, fwd, late, ldBusy}, 32'd1);
    @(negedge clk);
    cacheWrReady = 1'b1;
    seen = 1'b0;
    for (int w = 0; w < 8 && !seen; w++) begin
      @(negedge clk);
      #0.5;
      if (cacheRdValid) seen = 1'b1;
    end
    chk(seen && cacheRdAddr == 32'h0000_7001 && cacheWrValid == 1'b0, "R8",
        "misaligned goes to cache after drain", cacheRdAddr, 32'h0000_7001);
    @(negedge clk);
    cacheWrReady = 1'b0;

    // R2: fill all entries, extra store refused
    for (int n = 0; n < 8; n++) storeOp(32'(n + 1) << 8, 2'd2, 32'(n));
    #0.5;
    chk(stReady == 1'b0, "R2", "stReady when full", 32'(stReady), 32'd0);
    @(negedge clk);
    stValid = 1'b1; stAddr = 32'h0000_0900; stSize = 2'd2; stData = 32'h9;
    @(negedge clk);
    stValid = 1'b0; cacheWrReady = 1'b1;
    for (int n = 0; n < 8; n++) begin
      #0.5;
      chk(cacheWrValid && cacheWrAddr == (32'(n + 1) << 8), "R3", "fill order",
          cacheWrAddr, 32'(n + 1) << 8);
      @(negedge clk);
      if (n == 0) chk(stReady == 1'b1, "R2", "room after one drain", 32'(stReady), 32'd1);
    end
    #0.5;
    chk(cacheWrValid == 1'b0, "R2", "refused store never entered", 32'(cacheWrValid), 32'd0);
    cacheWrReady = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule